// File: doc/BRIEF.md
# Dual-Phase Serial Audio Transmitter

This block turns parallel audio words into a serial bit stream that a codec can take in. A frame starts on a rising edge of the frame sync. It holds one or two phases. Each phase has its own word count and its own word length, picked from a small table of encoded lengths. The first data bit follows the sync edge either in the same bit slot or one slot later. This covers both the "sync right before data" style of framing and the "sync one bit ahead of data" style.

All logic runs on one system clock. A one-cycle strobe, `bit_tick`, marks each launch edge of the bit clock, so each new bit is valid by the following capture edge. Words reach the block through a one-word holding register: `tx_valid` says it is full, and `tx_req` tells the host that a word was just moved into the shifter. A host that falls behind gets a repeated word and a sticky underrun flag. A sync edge that arrives in the middle of a frame is either ignored or flagged as a sync error and used to restart the frame, chosen by a configuration bit. Clearing the release input `tx_en` returns the block to idle and clears both flags.

Top module: `dual_phase_serial_tx`

## Requirements
- R1: Immediately after reset, and whenever `tx_en` is low, `sdo`, `tx_req`, `sync_err` and `underrun` are 0. With `tx_en` low, sync edges start no frame and no word is taken.
- R2: The word length code (cfg[2:0] for phase 1, cfg[12:10] for phase 2) maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5 (or 6, 7)→32 bits. A word of length L is taken from `tx_data[L-1:0]` and sent MSB first; higher bits are ignored.
- R3: A sync edge is a tick with `fsync`=1 that follows a tick with `fsync`=0. With delay bit cfg[21]=0 the MSB of the first word is driven on `sdo` after that same tick. With cfg[21]=1, `sdo` is 0 for that tick and the MSB follows one tick later.
- R4: With cfg[20]=0 a frame is cfg[9:3]+1 words of the phase-1 length. After the last bit, `sdo` returns to 0 until the next sync edge.
- R5: With cfg[20]=1 the phase-1 words are followed by cfg[19:13]+1 words of the phase-2 length, with no gap between them.
- R6: Each load of a word into the shifter raises `tx_req` for exactly one clock, in the cycle after the loading tick. If `tx_valid` was 1 at that tick, the held word is consumed.
- R7: If `tx_valid` is 0 at a load, the last consumed word is sent again and `underrun` is set. It stays set while `tx_en` is 1.
- R8: With ignore bit cfg[22]=0, a sync edge during an active frame (delay slot, or any tick before the one after the final bit) sets `sync_err`, which then stays set. The frame restarts from that edge.
- R9: With cfg[22]=1, a sync edge during an active frame has no effect on `sdo`, on word consumption or on `sync_err`.
- R10: A sync edge on the tick right after the final bit of a frame starts the next frame without a sync error.
- R11: Driving `tx_en` low for one clock clears `sync_err` and `underrun` and leaves the transmitter idle.
- R12: While `tx_en` is 1, `sdo` changes only in the cycle after a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe for each bit-clock launch edge |
| fsync | input | 1 | Frame sync level, sampled on ticks |
| tx_en | input | 1 | Transmitter release; low holds idle and clears flags |
| cfg | input | 2*FL_W+9 | Word lengths, word counts, phase, delay and ignore bits |
| tx_data | input | 32 | Holding register contents, right-justified |
| tx_valid | input | 1 | Holding register full |
| sdo | output | 1 | Serial data out |
| tx_req | output | 1 | Pulse: a word was just loaded into the shifter |
| sync_err | output | 1 | Sticky premature-sync flag |
| underrun | output | 1 | Sticky repeated-word flag |

## Verification
The tick where two things can collide is a word boundary. On that tick the shifter wants to load the next word, and a sync edge may arrive at the same moment. The bench places a sync edge on the tick right after a frame's final bit, where it must start a clean new frame. It also places one in the middle of a word, where it must either restart the frame with an error or be ignored, depending on the ignore bit. In each case the bench compares the collected `sdo` bit stream against the word sequence that the requirements predict, and checks the error flag and the number of words consumed.

// File: rtl/tx_pkg.sv
package tx_pkg;
  localparam int unsigned MAXW  = 32;
  localparam int unsigned LEN_W = $clog2(MAXW + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_DELAY = 2'd1,
    ST_SHIFT = 2'd2
  } tx_state_e;

  function automatic logic [LEN_W-1:0] code_to_len(input logic [2:0] code);
    case (code)
      3'd0:    code_to_len = LEN_W'(8);
      3'd1:    code_to_len = LEN_W'(12);
      3'd2:    code_to_len = LEN_W'(16);
      3'd3:    code_to_len = LEN_W'(20);
      3'd4:    code_to_len = LEN_W'(24);
      default: code_to_len = LEN_W'(MAXW);
    endcase
  endfunction
endpackage

// File: rtl/tx_frame_ctl.sv
module tx_frame_ctl
  import tx_pkg::*;
#(
  parameter int unsigned FL_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             fsync,
  input  logic [2:0]       wl1_code,
  input  logic [2:0]       wl2_code,
  input  logic [FL_W-1:0]  fl1,
  input  logic [FL_W-1:0]  fl2,
  input  logic             dual,
  input  logic             dly,
  input  logic             ign,
  output logic             do_load,
  output logic             do_shift,
  output logic             do_zero,
  output logic [LEN_W-1:0] load_len,
  output logic             sync_err
);
  tx_state_e        st_q, st_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic [FL_W-1:0]  wcnt_q, wcnt_d;
  logic             ph_q, ph_d;
  logic             fsp_q;
  logic             err_q, err_d;

  logic [LEN_W-1:0] len1, len2, len_cur;
  logic [FL_W-1:0]  fl_cur;
  logic             start, frame_last, frame_end, premature;

  always_comb begin
    len1       = code_to_len(wl1_code);
    len2       = code_to_len(wl2_code);
    fl_cur     = ph_q ? fl2 : fl1;
    len_cur    = ph_q ? len2 : len1;
    start      = tick && fsync && !fsp_q;
    frame_last = (left_q == '0) && (wcnt_q == fl_cur) && (ph_q || !dual);
    frame_end  = (st_q == ST_SHIFT) && frame_last;
    premature  = start && ((st_q == ST_DELAY) || ((st_q == ST_SHIFT) && !frame_last));

    st_d     = st_q;
    left_d   = left_q;
    wcnt_d   = wcnt_q;
    ph_d     = ph_q;
    err_d    = err_q;
    do_load  = 1'b0;
    do_shift = 1'b0;
    do_zero  = 1'b0;
    load_len = len1;

    if (!en) begin
      st_d    = ST_IDLE;
      left_d  = '0;
      wcnt_d  = '0;
      ph_d    = 1'b0;
      err_d   = 1'b0;
      do_zero = 1'b1;
    end else if (tick) begin
      if (start && ((st_q == ST_IDLE) || frame_end || (premature && !ign))) begin
        if (premature) err_d = 1'b1;
        ph_d   = 1'b0;
        wcnt_d = '0;
        if (dly) begin
          st_d    = ST_DELAY;
          do_zero = 1'b1;
        end else begin
          st_d     = ST_SHIFT;
          left_d   = len1 - 1'b1;
          do_load  = 1'b1;
          load_len = len1;
        end
      end else begin
        case (st_q)
          ST_IDLE: do_zero = 1'b1;
          ST_DELAY: begin
            st_d     = ST_SHIFT;
            left_d   = len1 - 1'b1;
            do_load  = 1'b1;
            load_len = len1;
          end
          ST_SHIFT: begin
            if (left_q != '0) begin
              left_d   = left_q - 1'b1;
              do_shift = 1'b1;
            end else if (frame_last) begin
              st_d    = ST_IDLE;
              do_zero = 1'b1;
            end else if (wcnt_q != fl_cur) begin
              wcnt_d   = wcnt_q + 1'b1;
              left_d   = len_cur - 1'b1;
              do_load  = 1'b1;
              load_len = len_cur;
            end else begin
              ph_d     = 1'b1;
              wcnt_d   = '0;
              left_d   = len2 - 1'b1;
              do_load  = 1'b1;
              load_len = len2;
            end
          end
          default: st_d = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      left_q <= '0;
      wcnt_q <= '0;
      ph_q   <= 1'b0;
      err_q  <= 1'b0;
    end else if (tick || !en) begin
      st_q   <= st_d;
      left_q <= left_d;
      wcnt_q <= wcnt_d;
      ph_q   <= ph_d;
      err_q  <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    fsp_q <= 1'b0;
    else if (tick) fsp_q <= fsync;
  end

  assign sync_err = err_q;

  // R8: an error can only appear after an un-ignored sync sample
  a_r8_err_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sync_err) |-> $past(tick && fsync && !ign && en));

  // R11: release low returns to idle with the error cleared
  a_r11_release_clear: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!sync_err && st_q == ST_IDLE));

  // R5: the second phase is only entered when dual-phase is configured
  a_r5_phase_needs_dual: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE && ph_q) |-> dual);
endmodule

// File: rtl/tx_shift_reg.sv
module tx_shift_reg
  import tx_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             do_load,
  input  logic             do_shift,
  input  logic             do_zero,
  input  logic [LEN_W-1:0] load_len,
  input  logic [MAXW-1:0]  tx_data,
  input  logic             tx_valid,
  output logic             sdo,
  output logic             tx_req,
  output logic             underrun
);
  logic [MAXW-1:0]  sh_q, sh_d;
  logic [MAXW-1:0]  last_q;
  logic             act_q, act_d;
  logic             req_q;
  logic             urun_q, urun_d;
  logic [MAXW-1:0]  src;
  logic [LEN_W-1:0] shamt;

  always_comb begin
    src    = tx_valid ? tx_data : last_q;
    shamt  = LEN_W'(MAXW) - load_len;
    sh_d   = sh_q;
    act_d  = act_q;
    urun_d = urun_q;
    if (do_zero) begin
      act_d = 1'b0;
    end else if (do_load) begin
      sh_d  = src << shamt;
      act_d = 1'b1;
      if (!tx_valid) urun_d = 1'b1;
    end else if (do_shift) begin
      sh_d = {sh_q[MAXW-2:0], 1'b0};
    end
    if (!en) urun_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      act_q  <= 1'b0;
      urun_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      if (do_load || do_shift || do_zero) begin
        sh_q  <= sh_d;
        act_q <= act_d;
      end
      urun_q <= urun_d;
      req_q  <= do_load;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   last_q <= '0;
    else if (do_load && tx_valid) last_q <= tx_data;
  end

  assign sdo      = sh_q[MAXW-1] & act_q;
  assign tx_req   = req_q;
  assign underrun = urun_q;

  // R6: the request strobe is a single-cycle pulse
  a_r6_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req |=> !tx_req);

  // R7: underrun stays set while released
  a_r7_urun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underrun && en) |=> underrun);

  // R12: no shifter activity means a steady serial output
  a_r12_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !do_load && !do_shift && !do_zero) |=> $stable(sdo));
endmodule

// File: rtl/dual_phase_serial_tx.sv
module dual_phase_serial_tx
  import tx_pkg::*;
#(
  parameter int unsigned FL_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              fsync,
  input  logic              tx_en,
  input  logic [2*FL_W+8:0] cfg,
  input  logic [MAXW-1:0]   tx_data,
  input  logic              tx_valid,
  output logic              sdo,
  output logic              tx_req,
  output logic              sync_err,
  output logic              underrun
);
  localparam int unsigned FL1_LSB = 3;
  localparam int unsigned WL2_LSB = FL1_LSB + FL_W;
  localparam int unsigned FL2_LSB = WL2_LSB + 3;
  localparam int unsigned DUAL_B  = FL2_LSB + FL_W;
  localparam int unsigned DLY_B   = DUAL_B + 1;
  localparam int unsigned IGN_B   = DUAL_B + 2;

  logic             do_load, do_shift, do_zero;
  logic [LEN_W-1:0] load_len;

  tx_frame_ctl #(.FL_W(FL_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (bit_tick),
    .en       (tx_en),
    .fsync    (fsync),
    .wl1_code (cfg[2:0]),
    .wl2_code (cfg[WL2_LSB +: 3]),
    .fl1      (cfg[FL1_LSB +: FL_W]),
    .fl2      (cfg[FL2_LSB +: FL_W]),
    .dual     (cfg[DUAL_B]),
    .dly      (cfg[DLY_B]),
    .ign      (cfg[IGN_B]),
    .do_load  (do_load),
    .do_shift (do_shift),
    .do_zero  (do_zero),
    .load_len (load_len),
    .sync_err (sync_err)
  );

  tx_shift_reg u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (tx_en),
    .do_load  (do_load),
    .do_shift (do_shift),
    .do_zero  (do_zero),
    .load_len (load_len),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .sdo      (sdo),
    .tx_req   (tx_req),
    .underrun (underrun)
  );
endmodule

// File: tb/test_dual_phase_serial_tx.sv
module test_dual_phase_serial_tx;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_tick, fsync, tx_en, tx_valid;
  logic [22:0] cfg;
  logic [31:0] tx_data;
  logic        sdo, tx_req, sync_err, underrun;

  int checks = 0;
  int errors = 0;
  int nreq, widx, nwords, stable_viol;
  logic [31:0] words [0:7];
  logic        exp_b [0:127];
  logic        got_b [0:127];
  int          ne;

  always #2 clk = ~clk;

  dual_phase_serial_tx i_dual_phase_serial_tx (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .fsync(fsync), .tx_en(tx_en),
    .cfg(cfg), .tx_data(tx_data), .tx_valid(tx_valid), .sdo(sdo), .tx_req(tx_req),
    .sync_err(sync_err), .underrun(underrun)
  );

  function automatic logic [22:0] mkcfg(input logic [2:0] wl1, input logic [6:0] fl1,
                                        input logic [2:0] wl2, input logic [6:0] fl2,
                                        input logic dual, input logic dly, input logic ign);
    mkcfg = {ign, dly, dual, fl2, wl2, fl1, wl1};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic refresh();
    tx_valid = (widx < nwords);
    tx_data  = (widx < nwords) ? words[widx] : 32'h0;
  endtask

  task automatic push(input logic [31:0] w, input int len, input int nb);
    for (int b = 0; b < nb; b++) begin
      exp_b[ne] = w[len-1-b];
      ne++;
    end
  endtask

  task automatic push_zero(input int n);
    for (int b = 0; b < n; b++) begin
      exp_b[ne] = 1'b0;
      ne++;
    end
  endtask

  // one bit period: tick cycle plus two quiet cycles
  task automatic bit_slot(input int t, input logic fs);
    logic v;
    @(negedge clk);
    v        = tx_valid;
    fsync    = fs;
    bit_tick = 1'b1;
    @(negedge clk);
    bit_tick = 1'b0;
    got_b[t] = sdo;
    if (tx_req) begin
      nreq++;
      if (v) begin
        widx++;
        refresh();
      end
    end
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      if (sdo !== got_b[t] || tx_req !== 1'b0) stable_viol++;
    end
  endtask

  task automatic run(input int nt, input int fa, input int fb);
    for (int t = 0; t < nt; t++) bit_slot(t, (t == fa) || (t == fb));
    fsync = 1'b0;
  endtask

  task automatic check_stream(input string req, input int nt);
    int bad = -1;
    for (int t = 0; t < nt; t++)
      if (bad < 0 && got_b[t] !== exp_b[t]) bad = t;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s: stream bit %0d actual %0b expected %0b", req, bad, got_b[bad], exp_b[bad]);
    end
  endtask

  task automatic setup(input logic [22:0] c, input int nw);
    tx_en  = 1'b0;
    cfg    = c;
    nwords = nw;
    widx   = 0;
    nreq   = 0;
    ne     = 0;
    refresh();
    repeat (2) @(negedge clk);
    tx_en = 1'b1;
    @(negedge clk);
  endtask

  task automatic release_off();
    @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 sdo after reset", {31'b0, sdo}, 32'h0);
    chk("R1 tx_req after reset", {31'b0, tx_req}, 32'h0);
    chk("R1 sync_err after reset", {31'b0, sync_err}, 32'h0);
    chk("R1 underrun after reset", {31'b0, underrun}, 32'h0);
  endtask

  task automatic t_single16_dly1();
    words[0] = 32'hFFFF_A5C3; words[1] = 32'h0000_1234;
    setup(mkcfg(3'd2, 7'd1, 3'd0, 7'd0, 1'b0, 1'b1, 1'b0), 2);
    push_zero(1); push(words[0], 16, 16); push(words[1], 16, 16); push_zero(3);
    run(36, 0, -1);
    check_stream("R2 R3 R4 single phase 16-bit delay 1", 36);
    chk("R6 request pulses", nreq, 2);
    chk("R6 words consumed", widx, 2);
    chk("R7 no underrun when fed", {31'b0, underrun}, 32'h0);
  endtask

  task automatic t_dual_8_32_dly0();
    words[0] = 32'h0000_005A; words[1] = 32'h8000_0001; words[2] = 32'hDEAD_BEEF;
    setup(mkcfg(3'd0, 7'd0, 3'd5, 7'd1, 1'b1, 1'b0, 1'b0), 3);
    push(words[0], 8, 8); push(words[1], 32, 32); push(words[2], 32, 32); push_zero(2);
    run(74, 0, -1);
    check_stream("R5 R3 dual phase 8+32 delay 0", 74);
    chk("R5 three words consumed", widx, 3);
  endtask

  task automatic t_dual_12_20();
    words[0] = 32'h0000_0ABC; words[1] = 32'h000F_1E2D;
    setup(mkcfg(3'd1, 7'd0, 3'd3, 7'd0, 1'b1, 1'b1, 1'b0), 2);
    push_zero(1); push(words[0], 12, 12); push(words[1], 20, 20); push_zero(2);
    run(35, 0, -1);
    check_stream("R2 codes 1 and 3 (12 and 20 bits)", 35);
  endtask

  task automatic t_single24();
    words[0] = 32'h77C3_9A15;
    setup(mkcfg(3'd4, 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0), 1);
    push(words[0], 24, 24); push_zero(3);
    run(27, 0, -1);
    check_stream("R2 code 4 (24 bits)", 27);
  endtask

  task automatic t_underrun();
    words[0] = 32'h0000_00C6;
    setup(mkcfg(3'd0, 7'd2, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0), 1);
    push(words[0], 8, 8); push(words[0], 8, 8); push(words[0], 8, 8); push_zero(2);
    run(26, 0, -1);
    check_stream("R7 starved words repeat", 26);
    chk("R7 underrun set", {31'b0, underrun}, 32'h1);
    chk("R6 request on every load", nreq, 3);
    release_off();
    chk("R11 underrun cleared by release low", {31'b0, underrun}, 32'h0);
  endtask

  task automatic t_premature(input logic ign);
    words[0] = 32'h0000_F0F0; words[1] = 32'h0000_3C3C;
    setup(mkcfg(3'd2, 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, ign), 2);
    if (!ign) begin
      push(words[0], 16, 5); push(words[1], 16, 16); push_zero(3);
    end else begin
      push(words[0], 16, 16); push_zero(8);
    end
    run(24, 0, 5);
    if (!ign) begin
      check_stream("R8 restart on premature sync", 24);
      chk("R8 sync_err set", {31'b0, sync_err}, 32'h1);
      release_off();
      chk("R11 sync_err cleared by release low", {31'b0, sync_err}, 32'h0);
    end else begin
      check_stream("R9 premature sync ignored", 24);
      chk("R9 no sync_err", {31'b0, sync_err}, 32'h0);
      chk("R9 second word not taken", widx, 1);
    end
  endtask

  task automatic t_back_to_back();
    words[0] = 32'h0000_0093; words[1] = 32'h0000_006E;
    setup(mkcfg(3'd0, 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0), 2);
    push(words[0], 8, 8); push(words[1], 8, 8); push_zero(2);
    run(18, 0, 8);
    check_stream("R10 sync right after final bit", 18);
    chk("R10 no sync_err", {31'b0, sync_err}, 32'h0);
  endtask

  task automatic t_disabled();
    words[0] = 32'hFFFF_FFFF;
    setup(mkcfg(3'd0, 7'd0, 3'd0, 7'd0, 1'b0, 1'b0, 1'b0), 1);
    tx_en = 1'b0;
    push_zero(20);
    run(20, 0, 10);
    check_stream("R1 no output while not released", 20);
    chk("R1 no request while not released", nreq, 0);
    chk("R1 no word taken while not released", widx, 0);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_tick = 1'b0; fsync = 1'b0; tx_en = 1'b0;
    cfg = '0; tx_data = '0; tx_valid = 1'b0;
    nreq = 0; widx = 0; nwords = 0; stable_viol = 0; ne = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single16_dly1();
    t_dual_8_32_dly0();
    t_dual_12_20();
    t_single24();
    t_underrun();
    t_premature(1'b0);
    t_premature(1'b1);
    t_back_to_back();
    t_disabled();
    chk("R12 sdo steady between ticks", stable_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule